// File: doc/BRIEF.md
# Per-Pin Input Event Interrupt Unit

This block turns changes and levels on a bank of already-synchronized input pins into per-pin interrupt lines. Each pin has four trigger kinds: a 0-to-1 change, a 1-to-0 change, a held 1 and a held 0. Each kind has its own enable word. Any enabled trigger sets that pin's sticky pending bit.

Software clears pending bits by writing ones to them. It can also set pending bits on purpose through a write-only test word. Each pin's interrupt output is its pending bit masked by a per-pin output enable.

Access goes through a simple single-cycle register port. Writes are accepted on any clock where the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every register reads 0, including the pending word, all enables and the previous-input sample. Every interrupt output is 0. The register addresses are: 0 pending (read, write-1-to-clear), 1 output enable, 2 test (write-only), 3 rise enable, 4 fall enable, 5 high-level enable, 6 low-level enable. Address 7 reads 0.
- R2: When a pin's input is 1 and was 0 on the previous clock, and its rise-enable bit is set, that pin's pending bit is 1 after the next clock edge. A pin whose rise-enable bit is clear does not become pending from that change.
- R3: When a pin's input is 0 and was 1 on the previous clock, and its fall-enable bit is set, that pin's pending bit is set.
- R4: While a pin's input is 1 and its high-level enable is set, its pending bit is set again on every clock. A clear written during that time has no lasting effect. The clear takes effect once the level is gone.
- R5: While a pin's input is 0 and its low-level enable is set, its pending bit is set on every clock.
- R6: Writing a 1 to a bit of the pending word clears it, unless a trigger hits that bit in the same clock. Writing a 0 leaves the bit unchanged.
- R7: A write of 1 to a bit of the test word sets that pending bit. The test word always reads 0. The test write has no effect after that clock, so a later clear stays cleared.
- R8: Each interrupt output equals its pending bit ANDed with its output-enable bit.
- R9: If a trigger and a clear write hit the same pending bit in the same clock, the bit ends up set.
- R10: The enable words read back exactly the value last written to them.
- R11: Change triggers compare the input against its value on the previous clock. Enabling rise detection while a pin is already 1 produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_in_i | input | NPINS | Synchronized pin values |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | NPINS | Register write data |
| reg_rdata_o | output | NPINS | Register read data (combinational) |
| irq_o | output | NPINS | Per-pin interrupt lines |

## Verification
The bench builds the block with its defaults: NPINS = 32 and AW = 3. This covers the full 32-bit word, so the top pin (bit 31) and mixed patterns across all pins are reached. Every one of the eight address codes is decodable, so the unmapped address is exercised too. Random writes to all addresses are mixed with random input words. This lets several trigger kinds overlap with clear and test writes on the same pin in the same clock.

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] data_in_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [NPINS-1:0] reg_wdata_i,
  output logic [NPINS-1:0] reg_rdata_o,
  output logic [NPINS-1:0] irq_o
);
  localparam logic [AW-1:0] A_PEND = AW'(0);
  localparam logic [AW-1:0] A_OEN  = AW'(1);
  localparam logic [AW-1:0] A_TEST = AW'(2);
  localparam logic [AW-1:0] A_RISE = AW'(3);
  localparam logic [AW-1:0] A_FALL = AW'(4);
  localparam logic [AW-1:0] A_HIGH = AW'(5);
  localparam logic [AW-1:0] A_LOW  = AW'(6);
  localparam logic [NPINS-1:0] ZERO = '0;

  logic [NPINS-1:0] prev_q, state_q, oen_q;
  logic [NPINS-1:0] en_rise_q, en_fall_q, en_high_q, en_low_q;
  logic [NPINS-1:0] hit, clr, force_set, state_d;

  wire wr_pend = reg_we_i && reg_addr_i == A_PEND;
  wire wr_test = reg_we_i && reg_addr_i == A_TEST;

  assign hit = (data_in_i & ~prev_q & en_rise_q)
             | (~data_in_i & prev_q & en_fall_q)
             | (data_in_i & en_high_q)
             | (~data_in_i & en_low_q);

  assign clr       = wr_pend ? reg_wdata_i : ZERO;
  assign force_set = wr_test ? reg_wdata_i : ZERO;
  assign state_d   = (state_q & ~clr) | hit | force_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      state_q   <= '0;
      oen_q     <= '0;
      en_rise_q <= '0;
      en_fall_q <= '0;
      en_high_q <= '0;
      en_low_q  <= '0;
    end else begin
      prev_q  <= data_in_i;
      state_q <= state_d;
      if (reg_we_i) begin
        case (reg_addr_i)
          A_OEN:   oen_q     <= reg_wdata_i;
          A_RISE:  en_rise_q <= reg_wdata_i;
          A_FALL:  en_fall_q <= reg_wdata_i;
          A_HIGH:  en_high_q <= reg_wdata_i;
          A_LOW:   en_low_q  <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_PEND:  reg_rdata_o = state_q;
      A_OEN:   reg_rdata_o = oen_q;
      A_RISE:  reg_rdata_o = en_rise_q;
      A_FALL:  reg_rdata_o = en_fall_q;
      A_HIGH:  reg_rdata_o = en_high_q;
      A_LOW:   reg_rdata_o = en_low_q;
      default: reg_rdata_o = ZERO;
    endcase
  end

  assign irq_o = state_q & oen_q;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPINS-1:0] data_in_i,
  input logic             reg_we_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic [NPINS-1:0] reg_wdata_i,
  input logic [NPINS-1:0] irq_o,
  input logic [NPINS-1:0] state_q,
  input logic [NPINS-1:0] prev_q,
  input logic [NPINS-1:0] oen_q,
  input logic [NPINS-1:0] en_rise_q,
  input logic [NPINS-1:0] en_fall_q,
  input logic [NPINS-1:0] en_high_q
);
  p_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(data_in_i & ~prev_q & en_rise_q)) |=>
      (($past(data_in_i & ~prev_q & en_rise_q) & ~state_q) == '0));

  p_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~data_in_i & prev_q & en_fall_q)) |=>
      (($past(~data_in_i & prev_q & en_fall_q) & ~state_q) == '0));

  p_level_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(data_in_i & en_high_q)) |=> (($past(data_in_i & en_high_q) & ~state_q) == '0));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == AW'(0)) |=> (($past(state_q) & ~state_q) == '0));

  p_test_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(2)) |=> (($past(reg_wdata_i) & ~state_q) == '0));

  p_irq_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oen_q == '0) |-> (irq_o == '0));

  p_irq_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~state_q) == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_in_i(data_in_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .irq_o(irq_o),
  .state_q(state_q), .prev_q(prev_q), .oen_q(oen_q), .en_rise_q(en_rise_q),
  .en_fall_q(en_fall_q), .en_high_q(en_high_q)
);

// File: tb/test_gpio_irq_detect.sv
`timescale 1ns/1ps
module test_gpio_irq_detect;
  localparam int N  = 32;
  localparam int AW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] din = '0, wdata = '0;
  logic we = 0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] rdata, irq;

  int checks = 0, errors = 0;
  logic [N-1:0] m_prev, m_pend, m_oen, m_rise, m_fall, m_high, m_low;

  always #2.5 clk = ~clk;

  gpio_irq_detect #(.NPINS(N), .AW(AW)) i_gpio_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .data_in_i(din), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic [N-1:0] triggers(logic [N-1:0] d);
    return (d & ~m_prev & m_rise) | (~d & m_prev & m_fall) | (d & m_high) | (~d & m_low);
  endfunction

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = '0; m_pend = '0; m_oen = '0;
    m_rise = '0; m_fall = '0; m_high = '0; m_low = '0;
  endtask

  task automatic model_edge(logic w, logic [AW-1:0] a, logic [N-1:0] v, logic [N-1:0] d);
    logic [N-1:0] nxt;
    nxt = m_pend & ~((w && a == 0) ? v : '0);
    nxt = nxt | triggers(d) | ((w && a == 2) ? v : '0);
    if (w) case (a)
      1: m_oen  = v;
      3: m_rise = v;
      4: m_fall = v;
      5: m_high = v;
      6: m_low  = v;
      default: ;
    endcase
    m_pend = nxt;
    m_prev = d;
  endtask

  task automatic cyc(logic w, logic [AW-1:0] a, logic [N-1:0] v, logic [N-1:0] d);
    we = w; addr = a; wdata = v; din = d;
    @(posedge clk);
    model_edge(w, a, v, d);
    @(negedge clk);
    we = 0;
  endtask

  task automatic peek(string req);
    we = 0; addr = '0;
    #1;
    check(req, rdata, m_pend);
    check(req, irq, m_pend & m_oen);
  endtask

  task automatic rd(string req, logic [AW-1:0] a, logic [N-1:0] exp);
    we = 0; addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", AW'(a), '0);
    check("R1", irq, '0);

    // R2 rising edge, pin 0 enabled, pin 1 not
    cyc(1, 3, 32'h1, '0); cyc(0, 0, 0, '0);
    cyc(0, 0, 0, 32'h3);
    rd("R2", 0, 32'h1);
    // R6 write 0 keeps, write 1 clears
    cyc(1, 0, 32'h0, 32'h3); rd("R6", 0, 32'h1);
    cyc(1, 0, 32'h1, 32'h3); rd("R6", 0, 32'h0);

    // R3 falling on pin 2
    cyc(1, 4, 32'h4, 32'h7); cyc(0, 0, 0, 32'h7);
    cyc(0, 0, 0, 32'h3); rd("R3", 0, 32'h4);
    cyc(1, 0, 32'h4, 32'h3); rd("R3", 0, 32'h0);

    // R4 level high on pin 3: clear while held stays set
    cyc(1, 5, 32'h8, 32'hB); cyc(0, 0, 0, 32'hB); rd("R4", 0, 32'h8);
    cyc(1, 0, 32'h8, 32'hB); rd("R4", 0, 32'h8);
    cyc(0, 0, 0, 32'h3); rd("R4", 0, 32'h8);
    cyc(1, 0, 32'h8, 32'h3); rd("R4", 0, 32'h0);

    // R9 rising edge coincident with clear on pin 0
    cyc(0, 0, 0, 32'h2);
    cyc(1, 0, 32'h1, 32'h3); rd("R9", 0, 32'h1);
    cyc(1, 0, 32'h1, 32'h3); rd("R9", 0, 32'h0);

    // R5 level low on pin 4 (already 0)
    cyc(1, 6, 32'h10, 32'h3); rd("R5", 0, 32'h0);
    cyc(0, 0, 0, 32'h3); rd("R5", 0, 32'h10);
    cyc(1, 6, 32'h0, 32'h13); cyc(1, 0, 32'h10, 32'h13); rd("R5", 0, 32'h0);

    // R8 output gating
    cyc(1, 2, 32'h8000_0001, 32'h13);
    rd("R8", 0, 32'h8000_0001); check("R8", irq, '0);
    cyc(1, 1, 32'h8000_0000, 32'h13); #1 check("R8", irq, 32'h8000_0000);

    // R7 test reads 0, discarded after one clock
    rd("R7", 2, '0);
    cyc(1, 0, 32'hFFFF_FFFF, 32'h13); rd("R7", 0, 32'h0);
    cyc(0, 0, 0, 32'h13); rd("R7", 0, 32'h0); check("R7", irq, '0);

    // R11 enable rise while pin 5 already high
    cyc(0, 0, 0, 32'h33); cyc(1, 3, 32'h20, 32'h33);
    cyc(0, 0, 0, 32'h33); cyc(0, 0, 0, 32'h33); rd("R11", 0, 32'h0);

    // R10 readback
    rd("R10", 1, 32'h8000_0000); rd("R10", 3, 32'h20); rd("R10", 4, 32'h4);
    rd("R10", 5, 32'h8); rd("R10", 6, 32'h0); rd("R10", 7, 32'h0);

    // Random phase against model (R2..R9)
    d = 32'h33;
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic [N-1:0] v;
      a = AW'($urandom_range(0, 7));
      v = $urandom() & $urandom();
      if ($urandom_range(0, 3) == 0) d = $urandom();
      else d = d ^ (32'h1 << $urandom_range(0, N - 1));
      cyc($urandom_range(0, 2) != 0, a, v, d);
      peek("R2-mixed R6 R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule